// File: doc/BRIEF.md
# Hit Frame Buffer with Chained Serial Readout

This block records hit patterns during an acquisition window and sends them out later on one serial line. Each validated trigger that arrives while the window is open stores one frame: the 2-bit state of every channel, the current bunch-crossing count and an 8-bit chip label taken from configuration. With default parameters a frame is 160 bits, and the store holds 128 frames. A low-active flag reports a full store. Once full, further triggers are discarded.

Readout is shared among many chips through a token. A chip that receives the token sends all of its stored frames, oldest first, on its serial output. A low-active line shows that it is driving data. When it has finished, it empties its store and sends a one-cycle token pulse to the next chip. A chip with nothing stored passes the token on at once. The serial bit rate is one bit per slow tick, which is one fast clock cycle in eight. The same tick advances the bunch-crossing counter.

Top module: `hit_frame_buffer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tx_active_n` and `mem_full_n` are 1 and `token_out` and `ser_dout` are 0.
- R2: At each rising clock edge where `trig_valid` and `acq_win` are both 1, the store is not full and no readout is in progress, one frame `{chip_hdr, bcid, hit_bits}` is appended. The MSB is `chip_hdr[7]` and the LSB is `hit_bits[0]`. A trigger while `acq_win` is 0 stores nothing.
- R3: A slow tick occurs on the DIV-th rising edge after reset release and on every DIV-th edge after that (DIV = 8). The bunch-crossing count rises by one on each tick while `acq_win` is 1 and wraps modulo 2^BCID_W. A frame stored at a tick edge holds the count from before the increment.
- R4: When `ctr_clr_n` is 0 at an edge, the count becomes 0, and this overrides an increment. A frame stored at that same edge holds the count from before the clear.
- R5: `mem_full_n` goes to 0 at the edge that stores the DEPTH-th frame. Triggers while it is 0 store nothing.
- R6: A `token_in` pulse while idle with at least one frame stored starts readout. From the next cycle `tx_active_n` is 0 and `ser_dout` shows the MSB of the oldest frame. Each later slow tick moves to the next lower bit. After a frame's LSB, the next tick presents the MSB of the next frame.
- R7: At the tick that ends the LSB of the last frame, `tx_active_n` returns to 1, `token_out` is 1 for exactly one cycle, the store empties and `mem_full_n` returns to 1.
- R8: A `token_in` pulse while idle with no frame stored gives a one-cycle `token_out` pulse on the next cycle, and `tx_active_n` stays 1.
- R9: Triggers during readout store nothing, including a trigger at the edge that ends readout.
- R10: `ser_dout` is 0 whenever `tx_active_n` is 1.
- R11: `token_in` during readout has no effect on the serial stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctr_clr_n | input | 1 | Synchronous clear of the bunch-crossing count, active low |
| acq_win | input | 1 | Acquisition window open |
| trig_valid | input | 1 | Validated trigger, one cycle per event |
| hit_bits | input | 2*NCH | 2-bit state per channel, channel k in bits [2k+1:2k] |
| chip_hdr | input | HDR_W | Chip label from configuration |
| token_in | input | 1 | Readout token from the previous chip |
| token_out | output | 1 | Readout token to the next chip, one-cycle pulse |
| ser_dout | output | 1 | Serial frame data |
| tx_active_n | output | 1 | Low while this chip drives `ser_dout` |
| mem_full_n | output | 1 | Low while the store is full |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a trigger and an update of the bunch-crossing count. The bench places a trigger exactly on a slow-tick edge, and another on the same edge as a counter clear. It judges both from the count carried in the frames that are later shifted out, which must be the value from before the update. The second pair is the end of readout and a new trigger: a trigger is placed on the edge that ends the last bit. The bench checks that no frame appears in the next readout, which must pass the token on at once. A behavioural model built on a queue predicts every output on every cycle.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_e;
endpackage

// File: rtl/hfb_timebase.sv
module hfb_timebase #(
    parameter int DIV    = 8,
    parameter int BCID_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              run,
    output logic              tick,
    output logic [BCID_W-1:0] bcid
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [BCID_W-1:0] bcid;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.div == DIV_W'(DIV - 1));
        st_d.div = tick ? '0 : st_q.div + DIV_W'(1);
        if (!clr_n) begin
            st_d.bcid = '0;
        end else if (tick && run) begin
            st_d.bcid = st_q.bcid + BCID_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bcid = st_q.bcid;
endmodule

// File: rtl/hfb_store.sv
module hfb_store #(
    parameter int DEPTH = 128,
    parameter int FW    = 160
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req,
    input  logic                       blocked,
    input  logic                       clr,
    input  logic [FW-1:0]              wdata,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [FW-1:0]              rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_state_t;

    st_state_t st_d, st_q;
    logic [FW-1:0] mem_q [DEPTH];
    logic          we;

    always_comb begin
        st_d = st_q;
        full = (st_q.cnt == CNT_W'(DEPTH));
        we   = wr_req && !full && !blocked;
        if (clr) begin
            st_d.cnt = '0;
        end else if (we) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[st_q.cnt[PTR_W-1:0]] <= wdata;
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign count   = st_q.cnt;
endmodule

// File: rtl/hfb_serializer.sv
module hfb_serializer
    import hfb_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int FW    = 160
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       token_in,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [FW-1:0]              rd_data,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic                       busy,
    output logic                       dout,
    output logic                       token_out,
    output logic                       clr
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BIT_W = $clog2(FW);

    typedef struct packed {
        ser_state_e        state;
        logic [PTR_W-1:0]  rd_ptr;
        logic [BIT_W-1:0]  bit_idx;
        logic [FW-1:0]     sh;
        logic              tok;
    } ser_t;

    ser_t st_d, st_q;
    logic last_frame;
    logic last_bit;

    always_comb begin
        st_d       = st_q;
        st_d.tok   = 1'b0;
        clr        = 1'b0;
        last_frame = (CNT_W'(st_q.rd_ptr) == count - CNT_W'(1));
        last_bit   = (st_q.bit_idx == BIT_W'(FW - 1));
        case (st_q.state)
            SER_IDLE: begin
                if (token_in) begin
                    if (count == '0) begin
                        st_d.tok = 1'b1;
                    end else begin
                        st_d.state   = SER_SEND;
                        st_d.rd_ptr  = '0;
                        st_d.bit_idx = '0;
                        st_d.sh      = rd_data;
                    end
                end
            end
            SER_SEND: begin
                if (tick) begin
                    if (last_bit) begin
                        if (last_frame) begin
                            st_d.state = SER_IDLE;
                            st_d.sh    = '0;
                            st_d.tok   = 1'b1;
                            clr        = 1'b1;
                        end else begin
                            st_d.rd_ptr  = st_q.rd_ptr + PTR_W'(1);
                            st_d.bit_idx = '0;
                            st_d.sh      = rd_data;
                        end
                    end else begin
                        st_d.bit_idx = st_q.bit_idx + BIT_W'(1);
                        st_d.sh      = {st_q.sh[FW-2:0], 1'b0};
                    end
                end
            end
            default: st_d.state = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.state == SER_SEND);
    assign rd_addr   = busy ? st_q.rd_ptr + PTR_W'(1) : '0;
    assign dout      = st_q.sh[FW-1] & busy;
    assign token_out = st_q.tok;
endmodule

// File: rtl/hit_frame_buffer.sv
module hit_frame_buffer #(
    parameter int NCH    = 64,
    parameter int DEPTH  = 128,
    parameter int BCID_W = 24,
    parameter int HDR_W  = 8,
    parameter int DIV    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctr_clr_n,
    input  logic             acq_win,
    input  logic             trig_valid,
    input  logic [2*NCH-1:0] hit_bits,
    input  logic [HDR_W-1:0] chip_hdr,
    input  logic             token_in,
    output logic             token_out,
    output logic             ser_dout,
    output logic             tx_active_n,
    output logic             mem_full_n
);
    localparam int FW    = HDR_W + BCID_W + 2 * NCH;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              tick;
    logic [BCID_W-1:0] bcid;
    logic [FW-1:0]     frame;
    logic [FW-1:0]     rd_data;
    logic [PTR_W-1:0]  rd_addr;
    logic [CNT_W-1:0]  count;
    logic              full;
    logic              busy;
    logic              clr;

    assign frame = {chip_hdr, bcid, hit_bits};

    hfb_timebase #(.DIV(DIV), .BCID_W(BCID_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (ctr_clr_n),
        .run   (acq_win),
        .tick  (tick),
        .bcid  (bcid)
    );

    hfb_store #(.DEPTH(DEPTH), .FW(FW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (trig_valid && acq_win),
        .blocked (busy),
        .clr     (clr),
        .wdata   (frame),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .count   (count),
        .full    (full)
    );

    hfb_serializer #(.DEPTH(DEPTH), .FW(FW)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .token_in  (token_in),
        .count     (count),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .dout      (ser_dout),
        .token_out (token_out),
        .clr       (clr)
    );

    assign tx_active_n = !busy;
    assign mem_full_n  = !full;
endmodule

// File: rtl/hfb_checker.sv
module hfb_checker (
    input logic clk,
    input logic rst_n,
    input logic acq_win,
    input logic trig_valid,
    input logic token_in,
    input logic token_out,
    input logic ser_dout,
    input logic tx_active_n,
    input logic mem_full_n,
    input logic tick
);
    AST_TOKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out);  // R7
    AST_TOKEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |-> tx_active_n);  // R8
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active_n |-> !ser_dout);  // R10
    AST_FULL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_full_n) |-> $past(trig_valid && acq_win && tx_active_n));  // R5
    AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_full_n) |-> $past(!tx_active_n));  // R7
    AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active_n) |-> $past(token_in));  // R6
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active_n && $past(!tx_active_n) && !$past(tick)) |-> $stable(ser_dout));  // R6
endmodule

bind hit_frame_buffer hfb_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_win     (acq_win),
    .trig_valid  (trig_valid),
    .token_in    (token_in),
    .token_out   (token_out),
    .ser_dout    (ser_dout),
    .tx_active_n (tx_active_n),
    .mem_full_n  (mem_full_n),
    .tick        (tick)
);

// File: tb/tb_hit_frame_buffer.sv
`timescale 1ns/1ps
module tb_hit_frame_buffer;
    localparam int NCH   = 64;
    localparam int DEPTH = 16;
    localparam int BW    = 8;
    localparam int HW    = 8;
    localparam int DIV   = 8;
    localparam int FW    = HW + BW + 2 * NCH;

    logic clk = 1'b0;
    logic rst_n, ctr_clr_n, acq_win, trig_valid, token_in;
    logic [2*NCH-1:0] hit_bits;
    logic [HW-1:0]    chip_hdr;
    logic token_out, ser_dout, tx_active_n, mem_full_n;

    always #2 clk = ~clk;

    hit_frame_buffer #(.NCH(NCH), .DEPTH(DEPTH), .BCID_W(BW), .HDR_W(HW), .DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .ctr_clr_n(ctr_clr_n), .acq_win(acq_win),
        .trig_valid(trig_valid), .hit_bits(hit_bits), .chip_hdr(chip_hdr),
        .token_in(token_in), .token_out(token_out), .ser_dout(ser_dout),
        .tx_active_n(tx_active_n), .mem_full_n(mem_full_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural model
    logic [FW-1:0] m_q[$];
    int m_div, m_bcid, m_fi, m_bi, m_sz;
    bit m_send, m_tok, m_tk, m_snd;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_bcid = 0; m_q.delete(); m_send = 0;
            m_fi = 0; m_bi = 0; m_tok = 0;
        end else begin
            m_sz  = m_q.size();
            m_tk  = (m_div == DIV - 1);
            m_snd = m_send;
            m_div = m_tk ? 0 : m_div + 1;
            m_tok = 0;
            if (!m_snd && token_in) begin
                if (m_sz == 0) m_tok = 1;
                else begin m_send = 1; m_fi = 0; m_bi = 0; end
            end else if (m_snd && m_tk) begin
                if (m_bi == FW - 1) begin
                    if (m_fi == m_sz - 1) begin
                        m_send = 0; m_q.delete(); m_tok = 1;
                    end else begin
                        m_fi++; m_bi = 0;
                    end
                end else m_bi++;
            end
            if (trig_valid && acq_win && m_sz < DEPTH && !m_snd)
                m_q.push_back({chip_hdr, m_bcid[BW-1:0], hit_bits});
            if (!ctr_clr_n) m_bcid = 0;
            else if (m_tk && acq_win) m_bcid = (m_bcid + 1) % (1 << BW);
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        logic exp_d;
        #1;
        exp_d = m_send ? m_q[m_fi][FW-1-m_bi] : 1'b0;
        chk(ser_dout === exp_d, "R2/R3/R4/R6/R9/R10/R11 ser_dout", ser_dout, exp_d);
        chk(tx_active_n === !m_send, "R6/R7 tx_active_n", tx_active_n, !m_send);
        chk(mem_full_n === !(m_q.size() == DEPTH), "R5/R7 mem_full_n", mem_full_n,
            !(m_q.size() == DEPTH));
        chk(token_out === m_tok, "R7/R8 token_out", token_out, m_tok);
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic trig_once(input logic [2*NCH-1:0] h, input logic [HW-1:0] hd);
        @(negedge clk);
        trig_valid = 1'b1; hit_bits = h; chip_hdr = hd;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic pass_token();
        @(negedge clk);
        token_in = 1'b1;
        @(negedge clk);
        token_in = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_send);
    endtask

    function automatic logic [2*NCH-1:0] rnd_hits();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        rst_n = 0; ctr_clr_n = 1; acq_win = 0; trig_valid = 0; token_in = 0;
        hit_bits = '0; chip_hdr = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: idle state during reset
        chk(tx_active_n && mem_full_n && !token_out && !ser_dout, "R1 reset outputs",
            {tx_active_n, mem_full_n, token_out, ser_dout}, 4'b1100);
        rst_n = 1;
        @(posedge clk); #1;
        chk(tx_active_n && mem_full_n && !token_out && !ser_dout, "R1 after release",
            {tx_active_n, mem_full_n, token_out, ser_dout}, 4'b1100);

        // R8: empty store passes token at once
        @(negedge clk); token_in = 1;
        @(posedge clk); #1;
        chk(token_out === 1'b1, "R8 token pass", token_out, 1);
        chk(tx_active_n === 1'b1, "R8 no transmit", tx_active_n, 1);
        @(negedge clk); token_in = 0;

        // R2/R3/R4: acquisition with corner timings
        @(negedge clk); ctr_clr_n = 0;
        @(negedge clk); ctr_clr_n = 1; acq_win = 1;
        repeat (20) @(negedge clk);
        trig_once(rnd_hits(), 8'h3C);
        acq_win = 0;
        trig_once(rnd_hits(), 8'hFF);            // R2: outside window, dropped
        acq_win = 1;
        while (m_div != DIV - 1) @(negedge clk);
        trig_valid = 1; hit_bits = rnd_hits(); chip_hdr = 8'h5A;  // R3: on tick edge
        @(negedge clk); trig_valid = 0;
        repeat (13) @(negedge clk);
        ctr_clr_n = 0; trig_valid = 1; hit_bits = rnd_hits(); chip_hdr = 8'h81; // R4
        @(negedge clk); ctr_clr_n = 1; trig_valid = 0;
        repeat (11) @(negedge clk);
        trig_once(rnd_hits(), 8'h0F);
        trig_once(rnd_hits(), 8'hC3);
        acq_win = 0;

        // R6: readout; R11 token during readout; R9 trigger during readout
        pass_token();
        repeat (300) @(negedge clk);
        token_in = 1; @(negedge clk); token_in = 0;   // R11
        acq_win = 1;
        trig_once(rnd_hits(), 8'h11);                 // R9 mid-readout
        while (!(m_send && m_fi == m_q.size() - 1 && m_bi == FW - 1 && m_div == DIV - 1))
            @(negedge clk);
        trig_valid = 1; hit_bits = rnd_hits();         // R9 on final edge
        @(negedge clk); trig_valid = 0; acq_win = 0;
        chk(tx_active_n === 1'b1, "R7 readout ended", tx_active_n, 1);
        chk(mem_full_n === 1'b1, "R7 store emptied", mem_full_n, 1);
        // R9: nothing stored, so the token passes at once
        @(negedge clk); token_in = 1;
        @(posedge clk); #1;
        chk(token_out === 1'b1, "R9 no frame kept", token_out, 1);
        @(negedge clk); token_in = 0;

        // R5: fill beyond depth
        acq_win = 1;
        for (int i = 0; i < DEPTH + 4; i++) begin
            @(negedge clk); trig_valid = 1; hit_bits = rnd_hits(); chip_hdr = 8'(i);
        end
        @(negedge clk); trig_valid = 0; acq_win = 0;
        chk(mem_full_n === 1'b0, "R5 full flag", mem_full_n, 0);
        pass_token();
        wait_idle();
        @(negedge clk);
        chk(mem_full_n === 1'b1, "R7 full released", mem_full_n, 1);

        // R3: counter wrap
        @(negedge clk); ctr_clr_n = 0;
        @(negedge clk); ctr_clr_n = 1; acq_win = 1;
        repeat (DIV * (1 << BW) + 3 * DIV) @(negedge clk);
        trig_once(rnd_hits(), 8'h77);
        acq_win = 0;
        pass_token();
        wait_idle();
        repeat (4) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule